// File: doc/BRIEF.md
# Low-Power State Controller

This block sequences a processor core through three power states: Run, Halt-Grant and Doze. It takes three active-low requests: a clock-stop request, a doze request and a reset. From these it produces clock-enable levels for the core, the bus unit and the interrupt-controller unit, plus a PLL enable. It also produces two mask levels that tell the surrounding logic to stop recognising snoops and interrupts. The clock gating cells and the PLL sit outside this block and only consume these levels.

The stop and doze requests are asynchronous to the controller clock. Each passes through a synchroniser chain before the state register samples it. Reset is asserted at once and released through its own synchroniser. Doze can be reached only through Halt-Grant. While the controller is in Doze it responds only to the doze request being dropped, or to reset. It does not leave Doze when the clock-stop request is released.

All pins are plain control and status levels. Nothing flows as a stream, so there is no valid/ready handshake and no back-pressure.

Top module: `pwr_state_ctrl`

## Requirements
- R1: While `rst_n` is low, the controller is held in Run (`pwr_state` = 2'b00). All clock enables are 1, both masks are 0 and `grant_ack` is 0. The assertion takes effect without waiting for a clock edge.
- R2: `stpclk_n` and `slp_n` each pass through SYNC_STAGES flip-flops, with a default of 2. A change applied between two rising edges reaches `pwr_state` on the third rising edge after it, and not earlier.
- R3: In Run, a low `stpclk_n` moves the controller to Halt-Grant (`pwr_state` = 2'b01).
- R4: On entry to Halt-Grant from Run, `grant_ack` is high for exactly one cycle. It is the first cycle of Halt-Grant and has the same timing as the state change.
- R5: In Halt-Grant with `slp_n` high, a high `stpclk_n` returns the controller to Run.
- R6: A low `slp_n` has no effect while in Run.
- R7: In Halt-Grant, a low `slp_n` moves the controller to Doze (`pwr_state` = 2'b10). This transition takes priority over the return to Run.
- R8: In Doze, `core_clk_en`, `bus_clk_en` and `intc_clk_en` are 0, `pll_en` is 1, and `snoop_mask` and `irq_mask` are 1.
- R9: In Doze, `stpclk_n` has no effect. Only a high `slp_n` leaves Doze, and it always goes to Halt-Grant, which turns the bus and interrupt-controller enables back on.
- R10: In Halt-Grant, `core_clk_en` is 0, `bus_clk_en` and `intc_clk_en` are 1, and both masks are 0.
- R11: In Run, all three clock enables are 1 and both masks are 0. `pll_en` is 1 in every state.
- R12: Reset from Doze returns the controller to Run with all enables on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert and synchronised release |
| stpclk_n | input | 1 | Active-low clock-stop request, asynchronous |
| slp_n | input | 1 | Active-low doze request, asynchronous |
| core_clk_en | output | 1 | Core clock enable |
| bus_clk_en | output | 1 | Bus unit clock enable |
| intc_clk_en | output | 1 | Interrupt-controller unit clock enable |
| pll_en | output | 1 | PLL enable |
| snoop_mask | output | 1 | 1 = snoop requests must not be recognised |
| irq_mask | output | 1 | 1 = interrupt requests must not be recognised |
| grant_ack | output | 1 | One-cycle pulse on entry to Halt-Grant |
| pwr_state | output | 2 | Current state: 00 Run, 01 Halt-Grant, 10 Doze |

## Verification
The enables and masks are decoded directly from the state register. A wrong state therefore shows on `pwr_state` and on the enable and mask pins in the same cycle the register takes it, which is three edges after the input change. A skipped or extra synchroniser stage moves that edge by one, so the bench checks one cycle before and at the expected edge. A state entered by an illegal path, such as Doze directly from Run or Run directly from Doze, stays visible for at least one full cycle on the pins. A `grant_ack` of the wrong width or phase shows in the cycle after entry.

// File: rtl/pwr_pkg.sv
package pwr_pkg;
  typedef enum logic [1:0] {
    PS_RUN     = 2'b00,
    PS_HALTGNT = 2'b01,
    PS_DOZE    = 2'b10
  } pstate_e;
endpackage

// File: rtl/pwr_sync_chain.sv
module pwr_sync_chain #(
  parameter int          WIDTH   = 2,
  parameter int          STAGES  = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[s] <= {WIDTH{RST_VAL}};
      else if (s == 0) stage_q[s] <= d;
      else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/pwr_rst_sync.sv
module pwr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_in_n,
  output logic rst_out_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_in_n) begin
    if (!rst_in_n) chain_q <= '0;
    else chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_out_n = chain_q[STAGES-1];
endmodule

// File: rtl/pwr_fsm.sv
module pwr_fsm
  import pwr_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    stop_req,
  input  logic    doze_req,
  output pstate_e state_q,
  output logic    ack_q
);
  pstate_e state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      PS_RUN:     if (stop_req) state_d = PS_HALTGNT;
      PS_HALTGNT: begin
        if (doze_req)       state_d = PS_DOZE;
        else if (!stop_req) state_d = PS_RUN;
      end
      PS_DOZE:    if (!doze_req) state_d = PS_HALTGNT;
      default:    state_d = PS_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PS_RUN;
      ack_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      ack_q   <= (state_q == PS_RUN) && (state_d == PS_HALTGNT);
    end
  end

  // Doze is reachable only through Halt-Grant
  assert_doze_via_halt_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PS_DOZE && $past(state_q) != PS_DOZE) |-> $past(state_q) == PS_HALTGNT);

  // Leaving Run needs a synchronised stop request
  assert_run_exit_stop_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state_q) == PS_RUN && state_q != PS_RUN) |-> $past(stop_req));

  // Leaving Doze always lands in Halt-Grant
  assert_doze_exit_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state_q) == PS_DOZE && state_q != PS_DOZE) |-> state_q == PS_HALTGNT);

  // Grant pulse lasts one cycle and marks Halt-Grant
  assert_ack_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ack_q |=> !ack_q);
  assert_ack_state_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ack_q |-> (state_q == PS_HALTGNT && $past(state_q) == PS_RUN));
endmodule

// File: rtl/pwr_out_dec.sv
module pwr_out_dec
  import pwr_pkg::*;
(
  input  pstate_e state,
  output logic    core_en,
  output logic    bus_en,
  output logic    intc_en,
  output logic    mask_all
);
  always_comb begin
    core_en  = 1'b1;
    bus_en   = 1'b1;
    intc_en  = 1'b1;
    mask_all = 1'b0;
    unique case (state)
      PS_HALTGNT: core_en = 1'b0;
      PS_DOZE: begin
        core_en  = 1'b0;
        bus_en   = 1'b0;
        intc_en  = 1'b0;
        mask_all = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/pwr_state_ctrl.sv
module pwr_state_ctrl
  import pwr_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       stpclk_n,
  input  logic       slp_n,
  output logic       core_clk_en,
  output logic       bus_clk_en,
  output logic       intc_clk_en,
  output logic       pll_en,
  output logic       snoop_mask,
  output logic       irq_mask,
  output logic       grant_ack,
  output logic [1:0] pwr_state
);
  localparam int REQ_W = 2;

  logic             rst_sync_n;
  logic [REQ_W-1:0] req_sync_n;
  pstate_e          state;
  logic             mask_all;

  pwr_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk       (clk),
    .rst_in_n  (rst_n),
    .rst_out_n (rst_sync_n)
  );

  pwr_sync_chain #(.WIDTH(REQ_W), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .d     ({slp_n, stpclk_n}),
    .q     (req_sync_n)
  );

  pwr_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .stop_req (~req_sync_n[0]),
    .doze_req (~req_sync_n[1]),
    .state_q  (state),
    .ack_q    (grant_ack)
  );

  pwr_out_dec u_dec (
    .state    (state),
    .core_en  (core_clk_en),
    .bus_en   (bus_clk_en),
    .intc_en  (intc_clk_en),
    .mask_all (mask_all)
  );

  assign snoop_mask = mask_all;
  assign irq_mask   = mask_all;
  assign pll_en     = 1'b1;
  assign pwr_state  = state;

  // Masks only while every unit clock is off
  assert_mask_clocks_off_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    snoop_mask |-> (!core_clk_en && !bus_clk_en && !intc_clk_en && pll_en));

  // Bus clock drops only on entering Doze
  assert_bus_off_doze_R10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $fell(bus_clk_en) |-> pwr_state == 2'b10);

  // Core clock off whenever grant pulse is seen
  assert_ack_core_off_R10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    grant_ack |-> !core_clk_en && bus_clk_en);
endmodule

// File: tb/sim_pwr_state_ctrl.sv
`timescale 1ns/1ps
module sim_pwr_state_ctrl;
  logic clk = 1'b0;
  logic rst_n, stpclk_n, slp_n;
  logic core_clk_en, bus_clk_en, intc_clk_en, pll_en;
  logic snoop_mask, irq_mask, grant_ack;
  logic [1:0] pwr_state;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pwr_state_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .stpclk_n(stpclk_n), .slp_n(slp_n),
    .core_clk_en(core_clk_en), .bus_clk_en(bus_clk_en), .intc_clk_en(intc_clk_en),
    .pll_en(pll_en), .snoop_mask(snoop_mask), .irq_mask(irq_mask),
    .grant_ack(grant_ack), .pwr_state(pwr_state)
  );

  localparam logic [1:0] RUN = 2'b00, HGT = 2'b01, DOZ = 2'b10;
  localparam int NV = 12;
  // {stpclk_n, slp_n, expected state}
  localparam logic [3:0] VEC [NV] = '{
    {1'b1, 1'b1, RUN}, {1'b1, 1'b0, RUN}, {1'b1, 1'b1, RUN}, {1'b0, 1'b1, HGT},
    {1'b0, 1'b0, DOZ}, {1'b1, 1'b0, DOZ}, {1'b0, 1'b0, DOZ}, {1'b0, 1'b1, HGT},
    {1'b1, 1'b1, RUN}, {1'b0, 1'b1, HGT}, {1'b1, 1'b0, DOZ}, {1'b1, 1'b1, RUN}
  };

  // {core, bus, intc, pll, snoop_mask, irq_mask} per state
  function automatic logic [5:0] exp_outs(input logic [1:0] st);
    case (st)
      RUN:     return 6'b111100;
      HGT:     return 6'b011100;
      default: return 6'b000111;
    endcase
  endfunction

  function automatic logic [5:0] act_outs();
    return {core_clk_en, bus_clk_en, intc_clk_en, pll_en, snoop_mask, irq_mask};
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wait_neg(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    for (int c = 0; c < 100000 && !done; c++) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual hung expected finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; stpclk_n = 1'b1; slp_n = 1'b1;
    #1;
    chk("R1 state", {6'd0, pwr_state}, {6'd0, RUN});
    chk("R1 outs", {2'd0, act_outs()}, {2'd0, exp_outs(RUN)});
    chk("R1 ack", {7'd0, grant_ack}, 8'd0);
    wait_neg(3);
    rst_n = 1'b1;
    wait_neg(4);

    // Table walk: R3 R5 R6 R7 R8 R9 R10 R11
    for (int v = 0; v < NV; v++) begin
      stpclk_n = VEC[v][3];
      slp_n    = VEC[v][2];
      wait_neg(5);
      chk($sformatf("R3/R5/R6/R7/R9 state vec %0d", v), {6'd0, pwr_state}, {6'd0, VEC[v][1:0]});
      chk($sformatf("R8/R10/R11 outs vec %0d", v), {2'd0, act_outs()}, {2'd0, exp_outs(VEC[v][1:0])});
    end

    // R2 latency and R4 grant pulse, starting from Run
    stpclk_n = 1'b0;
    wait_neg(2);
    chk("R2 no early change", {6'd0, pwr_state}, {6'd0, RUN});
    chk("R2 no early ack", {7'd0, grant_ack}, 8'd0);
    wait_neg(1);
    chk("R2 change on third edge", {6'd0, pwr_state}, {6'd0, HGT});
    chk("R4 ack high", {7'd0, grant_ack}, 8'd1);
    wait_neg(1);
    chk("R4 ack one cycle", {7'd0, grant_ack}, 8'd0);
    chk("R10 halt-grant outs", {2'd0, act_outs()}, {2'd0, exp_outs(HGT)});

    // R7 priority: drop stop and raise doze together while in Halt-Grant
    stpclk_n = 1'b1; slp_n = 1'b0;
    wait_neg(5);
    chk("R7 doze has priority", {6'd0, pwr_state}, {6'd0, DOZ});

    // R9: doze exit goes to Halt-Grant first, then Run one cycle later
    slp_n = 1'b1;
    wait_neg(3);
    chk("R9 doze exit to halt", {6'd0, pwr_state}, {6'd0, HGT});
    chk("R9 bus and intc back on", {6'd0, bus_clk_en, intc_clk_en}, 8'd3);
    chk("R4 no ack leaving doze", {7'd0, grant_ack}, 8'd0);
    wait_neg(1);
    chk("R5 run after halt", {6'd0, pwr_state}, {6'd0, RUN});

    // R12: reset out of Doze
    stpclk_n = 1'b0; wait_neg(5);
    slp_n = 1'b0; wait_neg(5);
    chk("R12 in doze before reset", {6'd0, pwr_state}, {6'd0, DOZ});
    rst_n = 1'b0; stpclk_n = 1'b1; slp_n = 1'b1;
    #1;
    chk("R12 reset to run", {6'd0, pwr_state}, {6'd0, RUN});
    chk("R12 enables on", {2'd0, act_outs()}, {2'd0, exp_outs(RUN)});
    wait_neg(3);
    rst_n = 1'b1;
    wait_neg(5);
    chk("R1 run after release", {6'd0, pwr_state}, {6'd0, RUN});
    chk("R11 pll on", {7'd0, pll_en}, 8'd1);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule